// File: doc/BRIEF.md
# Mode-Dependent Processor Clock Divider

This block derives the processor clock from a master clock and delivers it as a single-cycle clock-enable pulse in the master clock domain. One pulse per master cycle means the processor runs at the full master rate. One pulse every 2, 4 or 8 cycles gives the divided rates. No pulses means the processor clock is stopped. Downstream logic gates its processor-domain registers with this enable, so the block never produces a runt edge.

Two 2-bit fields set the rate, and a sleep input chooses which field applies. In run mode the four codes mean full rate, /2, /4 and /8. In sleep mode code 0 stops the clock and the other three codes again mean /2, /4 and /8. While a memory refresh, a DMA transfer or a bus-master cycle is in progress, the block forces full rate whatever the mode and the fields say. A new rate is adopted only where the current period ends. A period that has started always runs to its full length, and every new rate begins with a complete period.

Top module: `cpu_clk_div`

## Requirements
- R1: While reset is asserted the enable output is low. On the first master cycle after reset is released, with run mode and run code 0, a pulse appears, and pulses continue on every cycle.
- R2: In run mode with no override, run codes 0, 1, 2 and 3 give one enable pulse every 1, 2, 4 and 8 master cycles.
- R3: In sleep mode with no override, sleep codes 1, 2 and 3 give one enable pulse every 2, 4 and 8 master cycles.
- R4: In sleep mode with sleep code 0 and no override, the enable output stays low after the current period has ended.
- R5: While any of the refresh, DMA or bus-master inputs is high, the enable pulses on every master cycle once the current period has ended, in either mode and with any code.
- R6: A rate change, including entry into the full-rate override, does not cut short the period in progress. The next pulse comes exactly one old period after the previous pulse.
- R7: When a stopped clock is given a non-stop request, the enable rises on the master cycle right after the edge that samples the request, and for full rate it pulses again on the following cycle.
- R8: After a rate change, the first period at the new rate has the full new length and is not shortened by counter state left over from the old rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | High selects the sleep-mode field, low selects the run-mode field |
| run_div_i | input | SEL_W | Run-mode rate code: 0 full, 1 /2, 2 /4, 3 /8 |
| slp_div_i | input | SEL_W | Sleep-mode rate code: 0 stopped, 1 /2, 2 /4, 3 /8 |
| refresh_i | input | 1 | Memory refresh cycle in progress; forces full rate |
| dma_i | input | 1 | DMA cycle in progress; forces full rate |
| busmst_i | input | 1 | Bus-master cycle in progress; forces full rate |
| cpu_ce_o | output | 1 | Processor clock enable, one master-cycle pulse per processor clock |

## Verification
The bench measures the spacing between pulses for every run code and every sleep code, and for each of the three override sources. A decode that swapped the two encodings, or treated sleep code 0 as full rate, would show the wrong spacing or stray pulses while stopped. An override is applied one cycle into a /8 period, and the bench checks that the pulse still arrives 8 cycles after the previous one and then repeats every cycle. A design that switched rates mid-period would emit an early pulse here. A change from /4 to /8 made mid-period checks for one 4-cycle period followed by a full 8-cycle period, which catches a counter that is not restarted at the boundary. Leaving the stopped state must produce a pulse on the very next cycle; a design that waited on a stale count would lag.

// File: rtl/cpu_clk_div_pkg.sv
package cpu_clk_div_pkg;

   localparam int MAX_SEL_W = 3;

   // Effective rate: stopped, or divide by 2**lg
   typedef struct packed {
      logic                 stop;
      logic [MAX_SEL_W-1:0] lg;
   } rate_t;

endpackage

// File: rtl/cpu_clk_div_req.sv
module cpu_clk_div_req
   import cpu_clk_div_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             sleep_i,
   input  logic [SEL_W-1:0] run_div_i,
   input  logic [SEL_W-1:0] slp_div_i,
   input  logic             ovr_i,
   output rate_t            req_o
);

   always_comb begin
      req_o = '0;
      if (ovr_i) begin
         req_o.stop = 1'b0;
         req_o.lg   = '0;
      end else if (sleep_i) begin
         req_o.stop = (slp_div_i == '0);
         req_o.lg   = MAX_SEL_W'(slp_div_i);
      end else begin
         req_o.stop = 1'b0;
         req_o.lg   = MAX_SEL_W'(run_div_i);
      end
   end

endmodule

// File: rtl/cpu_clk_div_phase.sv
module cpu_clk_div_phase
   import cpu_clk_div_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  rate_t req_i,
   output logic  ce_o
);

   localparam int NRAT  = 1 << SEL_W;
   localparam int CNT_W = NRAT - 1;

   logic             stop_q;
   logic [SEL_W-1:0] lg_q;
   logic [CNT_W-1:0] cnt_q;
   logic [NRAT-1:0]  term;
   logic             bnd;

   // Terminal count per ratio: low lg bits of the phase counter all ones
   for (genvar i = 0; i < NRAT; i++) begin : g_term
      if (i == 0) begin : g_full
         assign term[i] = 1'b1;
      end else begin : g_div
         assign term[i] = &cnt_q[i-1:0];
      end
   end

   assign bnd  = stop_q | term[lg_q];
   assign ce_o = ~stop_q & term[lg_q];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stop_q <= 1'b1;
         lg_q   <= '0;
         cnt_q  <= '0;
      end else if (bnd) begin
         stop_q <= req_i.stop;
         lg_q   <= req_i.lg[SEL_W-1:0];
         cnt_q  <= '0;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/cpu_clk_div.sv
module cpu_clk_div
   import cpu_clk_div_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sleep_i,
   input  logic [SEL_W-1:0] run_div_i,
   input  logic [SEL_W-1:0] slp_div_i,
   input  logic             refresh_i,
   input  logic             dma_i,
   input  logic             busmst_i,
   output logic             cpu_ce_o
);

   if (SEL_W < 1 || SEL_W > MAX_SEL_W) begin : g_bad_sel_w
      $error("cpu_clk_div: SEL_W must lie in 1..%0d", MAX_SEL_W);
   end

   logic  ovr;
   rate_t req;

   assign ovr = refresh_i | dma_i | busmst_i;

   cpu_clk_div_req #(.SEL_W(SEL_W)) u_req (
      .sleep_i   (sleep_i),
      .run_div_i (run_div_i),
      .slp_div_i (slp_div_i),
      .ovr_i     (ovr),
      .req_o     (req)
   );

   cpu_clk_div_phase #(.SEL_W(SEL_W)) u_phase (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req),
      .ce_o   (cpu_ce_o)
   );

endmodule

// File: rtl/cpu_clk_div_chk.sv
module cpu_clk_div_chk #(
   parameter int SEL_W = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             sleep_i,
   input logic [SEL_W-1:0] run_div_i,
   input logic [SEL_W-1:0] slp_div_i,
   input logic             refresh_i,
   input logic             dma_i,
   input logic             busmst_i,
   input logic             cpu_ce_o
);

   logic ovr, c_full, c_stop, c_div2;
   logic [3:0] h_full, h_stop, h_div2;

   assign ovr    = refresh_i | dma_i | busmst_i;
   assign c_full = ovr | (~sleep_i & (run_div_i == '0));
   assign c_stop = ~ovr & sleep_i & (slp_div_i == '0);
   assign c_div2 = ~ovr & (sleep_i ? (slp_div_i == SEL_W'(1)) : (run_div_i == SEL_W'(1)));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         h_full <= '0;
         h_stop <= '0;
         h_div2 <= '0;
      end else begin
         h_full <= !c_full ? 4'd0 : (h_full == 4'hF ? h_full : h_full + 4'd1);
         h_stop <= !c_stop ? 4'd0 : (h_stop == 4'hF ? h_stop : h_stop + 4'd1);
         h_div2 <= !c_div2 ? 4'd0 : (h_div2 == 4'hF ? h_div2 : h_div2 + 4'd1);
      end
   end

   AST_FULL_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c_full && h_full >= 4'd9) |-> cpu_ce_o);                                  // R5

   AST_STOP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c_stop && h_stop >= 4'd9) |-> !cpu_ce_o);                                 // R4

   AST_DIV2_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c_div2 && h_div2 >= 4'd10) |-> (cpu_ce_o != $past(cpu_ce_o)));            // R2

   AST_RESUME_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((c_stop && h_stop >= 4'd9) ##1 c_full) |=> cpu_ce_o);                     // R7

endmodule

bind cpu_clk_div cpu_clk_div_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_cpu_clk_div.sv
module tb_cpu_clk_div;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int SEL_W = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sleep = 1'b0;
   logic             rf = 1'b0, dm = 1'b0, bm = 1'b0;
   logic [SEL_W-1:0] run_div = '0;
   logic [SEL_W-1:0] slp_div = '0;
   logic             ce;

   int    checks = 0;
   int    errors = 0;
   bit    finished = 1'b0;
   int    exp_q[$];
   string tag_q[$];
   bit    measure = 1'b0;
   int    cyc = 0;
   int    last = 0;
   bit    last_ok = 1'b0;

   always #2.5 clk = ~clk;

   cpu_clk_div #(.SEL_W(SEL_W)) dut (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .sleep_i   (sleep),
      .run_div_i (run_div),
      .slp_div_i (slp_div),
      .refresh_i (rf),
      .dma_i     (dm),
      .busmst_i  (bm),
      .cpu_ce_o  (ce)
   );

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_sim();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // Monitor: measures pulse spacing and compares with the scoreboard queue
   always @(negedge clk) begin
      int    e;
      string t;
      cyc++;
      if (ce) begin
         if (measure && last_ok && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check((cyc - last) == e, t, cyc - last, e);
         end
         last    = cyc;
         last_ok = measure;
      end
   end

   task automatic apply(bit s, int rsel, int ssel, bit r, bit d, bit b);
      @(negedge clk);
      #1;
      sleep   = s;
      run_div = SEL_W'(rsel);
      slp_div = SEL_W'(ssel);
      rf      = r;
      dm      = d;
      bm      = b;
   endtask

   // Driver: apply a setting, let it settle, push expected spacings
   task automatic sweep(bit s, int rsel, int ssel, bit r, bit d, bit b, int gap, string tag);
      apply(s, rsel, ssel, r, d, b);
      repeat (12) @(negedge clk);
      #1;
      for (int i = 0; i < 4; i++) begin
         exp_q.push_back(gap);
         tag_q.push_back(tag);
      end
      measure = 1'b1;
      while (exp_q.size() > 0) @(negedge clk);
      #1 measure = 1'b0;
   endtask

   task automatic wait_pulse();
      do @(negedge clk); while (!ce);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      check(ce == 1'b0, "R1 low in reset", int'(ce), 0);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(ce == 1'b1, "R1 first pulse after reset", int'(ce), 1);
      @(negedge clk);
      check(ce == 1'b1, "R1 second pulse after reset", int'(ce), 1);

      sweep(0, 0, 0, 0, 0, 0, 1, "R2 run code 0");
      sweep(0, 1, 0, 0, 0, 0, 2, "R2 run code 1");
      sweep(0, 2, 0, 0, 0, 0, 4, "R2 run code 2");
      sweep(0, 3, 0, 0, 0, 0, 8, "R2 run code 3");
      sweep(1, 0, 1, 0, 0, 0, 2, "R3 sleep code 1");
      sweep(1, 0, 2, 0, 0, 0, 4, "R3 sleep code 2");
      sweep(1, 3, 3, 0, 0, 0, 8, "R3 sleep code 3");
      sweep(1, 0, 0, 1, 0, 0, 1, "R5 refresh over stop");
      sweep(0, 3, 0, 0, 1, 0, 1, "R5 dma over run /8");
      sweep(1, 2, 3, 0, 0, 1, 1, "R5 master over sleep /8");

      // Stopped clock stays low
      apply(1, 0, 0, 0, 0, 0);
      repeat (12) @(negedge clk);
      n = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (ce) n++;
      end
      check(n == 0, "R4 pulses while stopped", n, 0);

      // Resume from stop
      apply(0, 0, 0, 0, 0, 0);
      @(negedge clk);
      check(ce == 1'b1, "R7 first pulse after stop", int'(ce), 1);
      @(negedge clk);
      check(ce == 1'b1, "R7 second pulse after stop", int'(ce), 1);
      apply(1, 0, 0, 0, 0, 0);
      repeat (12) @(negedge clk);
      apply(1, 0, 0, 0, 1, 0);
      @(negedge clk);
      check(ce == 1'b1, "R7 override ends stop", int'(ce), 1);

      // Override one cycle into a /8 period must wait for its end
      apply(0, 3, 0, 0, 0, 0);
      repeat (12) @(negedge clk);
      wait_pulse();
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            #1 rf = 1'b1;
         end
      end while (!ce);
      check(n == 8, "R6 period kept on override", n, 8);
      @(negedge clk);
      check(ce == 1'b1, "R6 full rate after boundary", int'(ce), 1);

      // /4 to /8 mid-period: old period completes, then a whole new period
      apply(0, 2, 0, 0, 0, 0);
      repeat (12) @(negedge clk);
      wait_pulse();
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (n == 2) begin
            #1 run_div = SEL_W'(3);
         end
      end while (!ce);
      check(n == 4, "R6 old /4 period kept", n, 4);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!ce);
      check(n == 8, "R8 first /8 period full", n, 8);

      finish_sim();
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", 20000);
      finish_sim();
   end

endmodule